// File: doc/BRIEF.md
# Register Forwarding Filter Unit

This unit sits on a segmented register-transaction bus and joins one segment to the next. It keeps a local copy of the architected registers for each execution path. Every entry carries the position tag of the instruction that last wrote it. A larger tag means a later point in program order. Update transactions from the earlier segment are merged into this copy and are always passed on to the later segment. Read requests from the later segment are answered locally when the stored version is older than the requester. Otherwise they are sent backward toward earlier segments.

The later-segment output carries a simple grant. While the grant is withheld, accepted updates wait in a first-in, first-out queue. When that queue is full, the input is back-pressured. Requests are not back-pressured. Each request produces exactly one registered outcome in the next cycle: either a local response or a backward request.

Top module: `reg_fwd_filter`

## Requirements
- R1: After a synchronous active-high reset, every stored entry is invalid, `upd_in_ready` is 1, and `upd_out_valid`, `rsp_valid` and `bwd_req_valid` are 0.
- R2: An accepted update (`upd_in_valid` and `upd_in_ready` both 1 at a clock edge) overwrites the entry for its path and register only if that entry is invalid or the update tag is strictly greater (unsigned) than the stored tag. In any other case the entry keeps its old tag and data.
- R3: Every accepted update appears on the forward output exactly once, with path, register, tag and data unchanged, in acceptance order. This holds whether or not R2 stored it.
- R4: If the output stage is empty, or is being granted while the queue is empty, an update accepted at one clock edge is presented on `upd_out_*` right after that same edge.
- R5: While `upd_out_valid` is 1 and `upd_out_grant` is 0, the forward output payload holds its value.
- R6: The unit holds at most QDEPTH + 1 outstanding updates: one in the output stage and QDEPTH in the queue. `upd_in_ready` is 0 exactly when that many are held. An update offered while ready is 0 is not taken.
- R7: A request whose entry is valid with a stored tag strictly below the request tag gets, one cycle later, `rsp_valid` = 1 with the request's path and register and the stored tag and data.
- R8: Any other request gets, one cycle later, `bwd_req_valid` = 1 carrying the request's path, register and tag, with no local response.
- R9: Entries of different paths are independent: an update on one path never changes what a request on another path sees.
- R10: A request in the same cycle as an update to the same entry is judged against the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_in_valid | input | 1 | Update offered from earlier segment |
| upd_in_ready | output | 1 | Unit can accept an update |
| upd_in_path | input | PW | Execution path of the update |
| upd_in_reg | input | AW | Register index of the update |
| upd_in_tag | input | TW | Position tag of the writer |
| upd_in_data | input | DW | Register value |
| upd_out_valid | output | 1 | Update presented to later segment |
| upd_out_grant | input | 1 | Later segment takes the presented update |
| upd_out_path | output | PW | Forwarded path |
| upd_out_reg | output | AW | Forwarded register index |
| upd_out_tag | output | TW | Forwarded tag |
| upd_out_data | output | DW | Forwarded value |
| req_in_valid | input | 1 | Read request from later segment |
| req_in_path | input | PW | Requested path |
| req_in_reg | input | AW | Requested register |
| req_in_tag | input | TW | Requester's position tag |
| rsp_valid | output | 1 | Local answer valid |
| rsp_path | output | PW | Path of answered request |
| rsp_reg | output | AW | Register of answered request |
| rsp_tag | output | TW | Tag of the stored version returned |
| rsp_data | output | DW | Stored value returned |
| bwd_req_valid | output | 1 | Request passed toward earlier segments |
| bwd_req_path | output | PW | Path of passed request |
| bwd_req_reg | output | AW | Register of passed request |
| bwd_req_tag | output | TW | Requester tag of passed request |

## Verification
A stored entry with the wrong tag or value shows up on the first later request for that register. It appears as a hit where a miss was due (or the reverse), or as a response carrying the wrong tag or data. That shows one cycle after the request. A miscounted queue shows as `upd_in_ready` at the wrong level, or as a forwarded update that is lost, duplicated or reordered. That is visible on the next cycle in which the output is compared against the expected order. Random traffic is confined to a few registers and a small tag range, so that tag collisions, equal tags and stale writes occur often.

// File: rtl/rff_pkg.sv
package rff_pkg;
  typedef enum logic [1:0] {
    ROUTE_IDLE  = 2'd0,
    ROUTE_LOCAL = 2'd1,
    ROUTE_BACK  = 2'd2
  } route_e;
endpackage

// File: rtl/rff_store.sv
module rff_store #(
  parameter int NPATH = 2,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int TW    = 8,
  parameter int PW    = 1,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_path,
  input  logic [AW-1:0] wr_reg,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_path,
  input  logic [AW-1:0] rd_reg,
  output logic          rd_vld,
  output logic [TW-1:0] rd_tag,
  output logic [DW-1:0] rd_data
);
  localparam int N  = NPATH * NREG;
  localparam int IW = PW + AW;

  logic [N-1:0]  vld_q;
  logic [TW-1:0] tag_q  [N];
  logic [DW-1:0] data_q [N];

  logic [IW-1:0] wi, ri;
  logic          win;

  assign wi  = {wr_path, wr_reg};
  assign ri  = {rd_path, rd_reg};
  // newer-wins merge rule
  assign win = wr_en && (!vld_q[wi] || (wr_tag > tag_q[wi]));

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (win) vld_q[wi] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (win) begin
      tag_q[wi]  <= wr_tag;
      data_q[wi] <= wr_data;
    end
  end

  assign rd_vld  = vld_q[ri];
  assign rd_tag  = tag_q[ri];
  assign rd_data = data_q[ri];

  // R2
  keep_newer_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && vld_q[wi] && !(wr_tag > tag_q[wi])) |=>
      (tag_q[$past(wi)] == $past(tag_q[wi])) && (data_q[$past(wi)] == $past(data_q[wi])));
endmodule

// File: rtl/rff_upd_queue.sv
module rff_upd_queue #(
  parameter int W     = 45,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_grant,
  output logic [W-1:0] out_data
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    fq [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic [CW-1:0]   cnt;
  logic            ov_q;
  logic [W-1:0]    od_q;
  logic            accept, load, fifo_pop, fifo_push;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign accept    = in_valid && in_ready;
  assign load      = !ov_q || out_grant;
  assign fifo_pop  = load && (cnt != '0);
  assign fifo_push = accept && !(load && (cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      cnt  <= '0;
      wp   <= '0;
      rp   <= '0;
    end else begin
      if (load) ov_q <= (cnt != '0) || accept;
      cnt <= cnt + CW'(fifo_push) - CW'(fifo_pop);
      if (fifo_push) wp <= (wp == PTRW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (fifo_pop)  rp <= (rp == PTRW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fifo_push) fq[wp] <= in_data;
    if (load) od_q <= (cnt != '0) ? fq[rp] : in_data;
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_grant) |=> (ov_q && $stable(od_q)));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH)) |-> !fifo_push);
  // R4
  stage_first_chk: assert property (@(posedge clk) disable iff (rst)
    !ov_q |-> (cnt == '0));
endmodule

// File: rtl/rff_req_filter.sv
module rff_req_filter
  import rff_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 8,
  parameter int PW = 1,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [PW-1:0] req_path,
  input  logic [AW-1:0] req_reg,
  input  logic [TW-1:0] req_tag,
  input  logic          st_vld,
  input  logic [TW-1:0] st_tag,
  input  logic [DW-1:0] st_data,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_path,
  output logic [AW-1:0] rsp_reg,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data,
  output logic          bwd_valid,
  output logic [PW-1:0] bwd_path,
  output logic [AW-1:0] bwd_reg,
  output logic [TW-1:0] bwd_tag
);
  route_e route;

  always_comb begin
    if (!req_valid)                      route = ROUTE_IDLE;
    else if (st_vld && (st_tag < req_tag)) route = ROUTE_LOCAL;
    else                                 route = ROUTE_BACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      bwd_valid <= 1'b0;
    end else begin
      rsp_valid <= (route == ROUTE_LOCAL);
      bwd_valid <= (route == ROUTE_BACK);
    end
  end

  always_ff @(posedge clk) begin
    rsp_path <= req_path;
    rsp_reg  <= req_reg;
    rsp_tag  <= st_tag;
    rsp_data <= st_data;
    bwd_path <= req_path;
    bwd_reg  <= req_reg;
    bwd_tag  <= req_tag;
  end

  // R7 R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid != bwd_valid));
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !bwd_valid));
endmodule

// File: rtl/reg_fwd_filter.sv
module reg_fwd_filter #(
  parameter int NPATH  = 2,
  parameter int NREG   = 16,
  parameter int DW     = 32,
  parameter int TW     = 8,
  parameter int QDEPTH = 4,
  localparam int PW = (NPATH > 1) ? $clog2(NPATH) : 1,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_in_valid,
  output logic          upd_in_ready,
  input  logic [PW-1:0] upd_in_path,
  input  logic [AW-1:0] upd_in_reg,
  input  logic [TW-1:0] upd_in_tag,
  input  logic [DW-1:0] upd_in_data,
  output logic          upd_out_valid,
  input  logic          upd_out_grant,
  output logic [PW-1:0] upd_out_path,
  output logic [AW-1:0] upd_out_reg,
  output logic [TW-1:0] upd_out_tag,
  output logic [DW-1:0] upd_out_data,
  input  logic          req_in_valid,
  input  logic [PW-1:0] req_in_path,
  input  logic [AW-1:0] req_in_reg,
  input  logic [TW-1:0] req_in_tag,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_path,
  output logic [AW-1:0] rsp_reg,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data,
  output logic          bwd_req_valid,
  output logic [PW-1:0] bwd_req_path,
  output logic [AW-1:0] bwd_req_reg,
  output logic [TW-1:0] bwd_req_tag
);
  localparam int UW = PW + AW + TW + DW;

  logic          upd_acc;
  logic          st_vld;
  logic [TW-1:0] st_tag;
  logic [DW-1:0] st_data;
  logic [UW-1:0] q_out;

  assign upd_acc = upd_in_valid && upd_in_ready;

  rff_store #(
    .NPATH(NPATH), .NREG(NREG), .DW(DW), .TW(TW), .PW(PW), .AW(AW)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(upd_acc), .wr_path(upd_in_path), .wr_reg(upd_in_reg),
    .wr_tag(upd_in_tag), .wr_data(upd_in_data),
    .rd_path(req_in_path), .rd_reg(req_in_reg),
    .rd_vld(st_vld), .rd_tag(st_tag), .rd_data(st_data)
  );

  rff_upd_queue #(.W(UW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .in_valid(upd_in_valid), .in_ready(upd_in_ready),
    .in_data({upd_in_path, upd_in_reg, upd_in_tag, upd_in_data}),
    .out_valid(upd_out_valid), .out_grant(upd_out_grant), .out_data(q_out)
  );

  assign {upd_out_path, upd_out_reg, upd_out_tag, upd_out_data} = q_out;

  rff_req_filter #(.DW(DW), .TW(TW), .PW(PW), .AW(AW)) u_filter (
    .clk(clk), .rst(rst),
    .req_valid(req_in_valid), .req_path(req_in_path),
    .req_reg(req_in_reg), .req_tag(req_in_tag),
    .st_vld(st_vld), .st_tag(st_tag), .st_data(st_data),
    .rsp_valid(rsp_valid), .rsp_path(rsp_path), .rsp_reg(rsp_reg),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .bwd_valid(bwd_req_valid), .bwd_path(bwd_req_path),
    .bwd_reg(bwd_req_reg), .bwd_tag(bwd_req_tag)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (upd_in_ready && !upd_out_valid && !rsp_valid && !bwd_req_valid));
  // R3
  accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
    upd_acc |=> upd_out_valid);
endmodule

// File: tb/reg_fwd_filter_tb.sv
`timescale 1ns/1ps
module reg_fwd_filter_tb;
  localparam int NP = 2, NR = 16, DW = 32, TW = 8, QD = 4, PW = 1, AW = 4;
  localparam int UW = PW + AW + TW + DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          upd_in_valid = 0, upd_out_grant = 0, req_in_valid = 0;
  logic          upd_in_ready, upd_out_valid, rsp_valid, bwd_req_valid;
  logic [PW-1:0] upd_in_path = 0, upd_out_path, req_in_path = 0, rsp_path, bwd_req_path;
  logic [AW-1:0] upd_in_reg = 0, upd_out_reg, req_in_reg = 0, rsp_reg, bwd_req_reg;
  logic [TW-1:0] upd_in_tag = 0, upd_out_tag, req_in_tag = 0, rsp_tag, bwd_req_tag;
  logic [DW-1:0] upd_in_data = 0, upd_out_data, rsp_data;

  reg_fwd_filter #(.NPATH(NP), .NREG(NR), .DW(DW), .TW(TW), .QDEPTH(QD)) u_dut (.*);

  int tests = 0, fails = 0;
  logic          mv [NP][NR];
  logic [TW-1:0] mt [NP][NR];
  logic [DW-1:0] md [NP][NR];
  logic [UW-1:0] q [$];
  logic          e_rsp = 0, e_bwd = 0;
  logic [PW-1:0] e_path;
  logic [AW-1:0] e_reg;
  logic [TW-1:0] e_tag;
  logic [DW-1:0] e_data;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic hit_model(input int p, input int r, input logic [TW-1:0] t);
    return mv[p][r] && (mt[p][r] < t);
  endfunction

  task automatic step(input logic uv, input int up, input int ur, input int ut, input logic [DW-1:0] ud,
                      input logic g, input logic rv, input int rp, input int rr, input int rt);
    logic acc, pop;
    chk("R6 ready", 64'(upd_in_ready), 64'(q.size() <= QD));
    chk("R3 out_valid", 64'(upd_out_valid), 64'(q.size() > 0));
    if (q.size() > 0)
      chk("R3 R4 R5 payload", 64'({upd_out_path, upd_out_reg, upd_out_tag, upd_out_data}), 64'(q[0]));
    chk("R7 R2 R9 R10 rsp_valid", 64'(rsp_valid), 64'(e_rsp));
    if (e_rsp && rsp_valid) chk("R7 R2 R10 rsp fields", 64'({rsp_path, rsp_reg, rsp_tag, rsp_data}),
                                 64'({e_path, e_reg, e_tag, e_data}));
    chk("R8 R1 R9 bwd_valid", 64'(bwd_req_valid), 64'(e_bwd));
    if (e_bwd && bwd_req_valid) chk("R8 bwd fields", 64'({bwd_req_path, bwd_req_reg, bwd_req_tag}),
                                     64'({e_path, e_reg, e_tag}));
    acc = uv && (q.size() <= QD);
    pop = g && (q.size() > 0);
    // R10: request judged on pre-update model
    e_rsp  = rv && hit_model(rp, rr, TW'(rt));
    e_bwd  = rv && !e_rsp;
    e_path = PW'(rp);
    e_reg  = AW'(rr);
    e_tag  = e_rsp ? mt[rp][rr] : TW'(rt);
    e_data = md[rp][rr];
    // R2 merge rule
    if (acc && (!mv[up][ur] || TW'(ut) > mt[up][ur])) begin
      mv[up][ur] = 1'b1;
      mt[up][ur] = TW'(ut);
      md[up][ur] = ud;
    end
    if (pop) void'(q.pop_front());
    if (acc) q.push_back({PW'(up), AW'(ur), TW'(ut), ud});
    upd_in_valid = uv; upd_in_path = PW'(up); upd_in_reg = AW'(ur);
    upd_in_tag = TW'(ut); upd_in_data = ud; upd_out_grant = g;
    req_in_valid = rv; req_in_path = PW'(rp); req_in_reg = AW'(rr); req_in_tag = TW'(rt);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) begin
        mv[p][r] = 0; mt[p][r] = 0; md[p][r] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(upd_in_ready), 64'd1);
    chk("R1 idle outputs", 64'({upd_out_valid, rsp_valid, bwd_req_valid}), 64'd0);
    step(0,0,0,0,0, 1, 1,0,3,255);                  // R1 empty entry -> backward
    step(1,0,5,10,32'hAAAA0001, 1, 0,0,0,0);        // store tag 10
    step(1,0,5,8,32'hBBBB0002, 1, 1,0,5,11);        // R7 hit; stale write offered
    step(0,0,0,0,0, 1, 1,0,5,10);                   // R8 equal tag -> miss
    step(0,0,0,0,0, 1, 1,0,5,12);                   // R2 stale write not stored
    step(0,0,0,0,0, 1, 1,1,5,200);                  // R9 other path empty
    step(1,0,5,20,32'hCCCC0003, 1, 1,0,5,30);       // R10 same-cycle read old
    step(0,0,0,0,0, 1, 1,0,5,30);                   // newer value visible
    // R6 R5 backpressure with grant held low
    for (int i = 0; i < 7; i++) step(1,1,i,i+1,32'h100 + i, 0, 0,0,0,0);
    step(0,0,0,0,0, 0, 0,0,0,0);
    for (int i = 0; i < 8; i++) step(0,0,0,0,0, 1, 0,0,0,0);
    // random traffic, small register/tag space for collisions
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 7, $urandom % NP, $urandom % 4, $urandom % 16, $urandom,
           ($urandom % 10) < 6, ($urandom % 10) < 6, $urandom % NP, $urandom % 4, $urandom % 16);
    for (int i = 0; i < 8; i++) step(0,0,0,0,0, 1, 0,0,0,0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule